// File: doc/BRIEF.md
# Bit Test, Modify and Scan Unit

This unit performs single-bit operations on one operand, and it can also search an operand for a set bit. A bit operation reads the old value of one selected bit and reports it on a zero flag. It then returns the operand with that bit left alone, forced to one, forced to zero or inverted. A scan searches the operand for a set bit, either upward from bit 0 or downward from the top bit, and returns the index of the first one it meets.

The caller presents the operand, a bit number, a size code and an operation code with a one-cycle `valid_i` strobe. All results are registered and appear with a `done_o` pulse on the next cycle. Each output holds its value until an operation that owns it runs again. The modified operand and the zero flag belong to the bit operations. The index and the found flag belong to the scans.

Top module: `bitop_scan_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after each cycle with `valid_i` high, and low otherwise.
- R2: Test (op code 0), and the unused op codes 6 and 7, leave `result_o` equal to the operand. They set `zero_o` to 1 exactly when the selected bit is 0.
- R3: Set (op 1) forces the selected bit to 1, clear (op 2) forces it to 0 and change (op 3) inverts it. Every other bit passes through unchanged. `zero_o` reports the selected bit as it was before the change.
- R4: Size code 0 (byte) takes the bit number modulo 8. Codes 1 and 2 and 3 take it modulo 32.
- R5: Scan forward (op 4) returns in `index_o` the lowest set bit position and drives `found_o` to 1. It scans bits 15..0 when the size code is 1 and bits 31..0 for any other size code.
- R6: Scan reverse (op 5) returns the highest set bit position within the same scanned width as R5, and drives `found_o` to 1.
- R7: A scan whose scanned bits are all zero drives `found_o` to 0 and leaves `index_o` unchanged.
- R8: A scan leaves `result_o` and `zero_o` unchanged. A bit operation leaves `index_o` and `found_o` unchanged.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 test, 1 set, 2 clear, 3 change, 4 scan forward, 5 scan reverse) |
| size_i | input | 2 | Size code (0 byte, 1 16-bit, 2 or 3 32-bit) |
| operand_i | input | 32 | Operand |
| bitnum_i | input | 5 | Selected bit number |
| result_o | output | 32 | Operand after the bit operation |
| zero_o | output | 1 | Selected bit was 0 before the operation |
| index_o | output | 5 | Scan result index |
| found_o | output | 1 | Scan found a set bit |
| done_o | output | 1 | Result valid pulse |

## Verification
A wrong bit-select decode shows up on the same operation. The result has the wrong bit changed, or more than one bit changed, and the zero flag disagrees, all one cycle after the strobe. A scan priority fault gives the wrong index on that same result cycle. A fault in the holding logic shows up only on the next operation of the other kind, so the bench compares all four outputs after every operation. This exposes an index or a result that an operation should not have touched.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  typedef enum logic [2:0] {
    OP_TST = 3'd0,
    OP_SET = 3'd1,
    OP_CLR = 3'd2,
    OP_CHG = 3'd3,
    OP_SCF = 3'd4,
    OP_SCR = 3'd5
  } bitu_op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic logic is_scan(input logic [2:0] op);
    return (op == OP_SCF) || (op == OP_SCR);
  endfunction
endpackage

// File: rtl/bitu_modify.sv
module bitu_modify #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int BIDX_W = $clog2(BYTE_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  bitnum_i,
  input  logic              byte_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  import bitu_pkg::*;

  logic [IDX_W-1:0]  sel;
  logic [DATA_W-1:0] mask;
  logic              old_bit;

  // modulo 8 for byte operands, full range otherwise
  assign sel = byte_i ? {{(IDX_W-BIDX_W){1'b0}}, bitnum_i[BIDX_W-1:0]} : bitnum_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (sel == IDX_W'(g));
  end

  assign old_bit = |(operand_i & mask);
  assign zero_o  = ~old_bit;

  always_comb begin
    unique case (op_i)
      OP_SET:  result_o = operand_i | mask;
      OP_CLR:  result_o = operand_i & ~mask;
      OP_CHG:  result_o = operand_i ^ mask;
      default: result_o = operand_i;
    endcase
  end
endmodule

// File: rtl/bitu_scan.sv
module bitu_scan #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              half_i,
  input  logic              reverse_i,
  output logic [IDX_W-1:0]  index_o,
  output logic              found_o
);
  logic [DATA_W-1:0] vec;
  logic [IDX_W-1:0]  idx_fwd, idx_rev;

  for (genvar g = 0; g < DATA_W; g++) begin : g_vec
    if (g < HALF_W) begin : g_low
      assign vec[g] = operand_i[g];
    end else begin : g_high
      assign vec[g] = operand_i[g] & ~half_i;
    end
  end

  // lowest set bit wins
  always_comb begin
    idx_fwd = '0;
    for (int i = DATA_W-1; i >= 0; i--) begin
      if (vec[i]) idx_fwd = IDX_W'(i);
    end
  end

  // highest set bit wins
  always_comb begin
    idx_rev = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) idx_rev = IDX_W'(i);
    end
  end

  assign index_o = reverse_i ? idx_rev : idx_fwd;
  assign found_o = |vec;
endmodule

// File: rtl/bitop_scan_unit.sv
module bitop_scan_unit #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  bitnum_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              found_o,
  output logic              done_o
);
  import bitu_pkg::*;

  logic [DATA_W-1:0] mod_res;
  logic              mod_zero;
  logic [IDX_W-1:0]  scan_idx;
  logic              scan_found;
  logic              scan_op;

  assign scan_op = is_scan(op_i);

  bitu_modify #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_modify (
    .operand_i (operand_i),
    .bitnum_i  (bitnum_i),
    .byte_i    (size_i == SZ_BYTE),
    .op_i      (op_i),
    .result_o  (mod_res),
    .zero_o    (mod_zero)
  );

  bitu_scan #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_scan (
    .operand_i (operand_i),
    .half_i    (size_i == SZ_HALF),
    .reverse_i (op_i == OP_SCR),
    .index_o   (scan_idx),
    .found_o   (scan_found)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      zero_o   <= 1'b0;
      index_o  <= '0;
      found_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        if (scan_op) begin
          found_o <= scan_found;
          if (scan_found) index_o <= scan_idx;
        end else begin
          result_o <= mod_res;
          zero_o   <= mod_zero;
        end
      end
    end
  end

  logic scan_empty;
  assign scan_empty = (size_i == SZ_HALF) ? (operand_i[HALF_W-1:0] == '0)
                                          : (operand_i == '0);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_o == $past(valid_i)));

  assert_test_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_TST) |=> (result_o == $past(operand_i)));

  assert_single_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !scan_op |=> ($countones(result_o ^ $past(operand_i)) <= 1));

  assert_set_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_SET) |=> (zero_o == (result_o != $past(operand_i))));

  assert_index_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scan_op && !scan_empty |=>
      found_o && ((($past(operand_i) >> index_o) & DATA_W'(1)) != '0));

  assert_empty_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scan_op && scan_empty |=> !found_o && $stable(index_o));

  assert_scan_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scan_op |=> $stable(result_o) && $stable(zero_o));
endmodule

// File: tb/bitop_scan_unit_tb.sv
module bitop_scan_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] operand_i = '0;
  logic [4:0]  bitnum_i = '0;
  logic [31:0] result_o;
  logic        zero_o;
  logic [4:0]  index_o;
  logic        found_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  logic [31:0] e_res = '0;
  logic        e_zero = 1'b0;
  logic [4:0]  e_idx = '0;
  logic        e_found = 1'b0;

  always #5 clk_i = ~clk_i;

  bitop_scan_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .size_i, .operand_i, .bitnum_i,
    .result_o, .zero_o, .index_o, .found_o, .done_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model of one operation
  task automatic model(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] opd, input logic [4:0] bn);
    int b;
    int w;
    int hit;
    if (op == 3'd4 || op == 3'd5) begin
      w = (sz == 2'd1) ? 16 : 32;
      hit = -1;
      for (int k = 0; k < w; k++) begin
        if (opd[k]) begin
          if (op == 3'd4 && hit < 0) hit = k;
          if (op == 3'd5) hit = k;
        end
      end
      e_found = (hit >= 0);
      if (hit >= 0) e_idx = 5'(hit);
    end else begin
      b = (sz == 2'd0) ? int'(bn) % 8 : int'(bn);
      e_zero = (opd[b] == 1'b0);
      e_res = opd;
      if (op == 3'd1) e_res[b] = 1'b1;
      if (op == 3'd2) e_res[b] = 1'b0;
      if (op == 3'd3) e_res[b] = ~opd[b];
    end
  endtask

  task automatic run(input string req, input logic [2:0] op, input logic [1:0] sz, input logic [31:0] opd, input logic [4:0] bn);
    @(negedge clk_i);
    op_i = op; size_i = sz; operand_i = opd; bitnum_i = bn; valid_i = 1'b1;
    model(op, sz, opd, bn);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1", "done", 32'(done_o), 32'd1);
    chk(req, "result", result_o, e_res);
    chk(req, "zero", 32'(zero_o), 32'(e_zero));
    chk(req, "index", 32'(index_o), 32'(e_idx));
    chk(req, "found", 32'(found_o), 32'(e_found));
  endtask

  task automatic t_reset;
    chk("R9", "result", result_o, 32'd0);
    chk("R9", "zero", 32'(zero_o), 32'd0);
    chk("R9", "index", 32'(index_o), 32'd0);
    chk("R9", "found", 32'(found_o), 32'd0);
    chk("R9", "done", 32'(done_o), 32'd0);
  endtask

  task automatic t_test;
    run("R2", 3'd0, 2'd2, 32'hA5A5_0F0F, 5'd4);
    run("R2", 3'd0, 2'd2, 32'hA5A5_0F0F, 5'd3);
    run("R2", 3'd6, 2'd2, 32'h8000_0000, 5'd31);
    run("R2", 3'd7, 2'd0, 32'h0000_0000, 5'd2);
  endtask

  task automatic t_modify;
    run("R3", 3'd1, 2'd2, 32'h0000_0000, 5'd31);
    run("R3", 3'd1, 2'd2, 32'hFFFF_FFFF, 5'd7);
    run("R3", 3'd2, 2'd2, 32'hFFFF_FFFF, 5'd16);
    run("R3", 3'd2, 2'd3, 32'h1234_5678, 5'd0);
    run("R3", 3'd3, 2'd2, 32'h0F0F_0F0F, 5'd8);
    run("R3", 3'd3, 2'd2, 32'h0F0F_0F0F, 5'd9);
  endtask

  task automatic t_modulo;
    run("R4", 3'd1, 2'd0, 32'h0000_0000, 5'd13);
    run("R4", 3'd3, 2'd0, 32'hFFFF_FF00, 5'd31);
    run("R4", 3'd2, 2'd1, 32'hFFFF_FFFF, 5'd20);
  endtask

  task automatic t_scan;
    run("R5", 3'd4, 2'd2, 32'h8001_0100, 5'd0);
    run("R5", 3'd4, 2'd1, 32'hFFFF_8000, 5'd0);
    run("R5", 3'd4, 2'd2, 32'h0000_0001, 5'd0);
    run("R6", 3'd5, 2'd2, 32'h8001_0100, 5'd0);
    run("R6", 3'd5, 2'd1, 32'hFFFF_0300, 5'd0);
    run("R6", 3'd5, 2'd2, 32'h0000_0001, 5'd0);
  endtask

  task automatic t_empty;
    run("R6", 3'd5, 2'd2, 32'h0004_0000, 5'd0);
    run("R7", 3'd4, 2'd1, 32'hFFFF_0000, 5'd0);
    run("R7", 3'd5, 2'd2, 32'h0000_0000, 5'd0);
    run("R5", 3'd4, 2'd2, 32'h0000_0008, 5'd0);
  endtask

  task automatic t_hold;
    run("R3", 3'd1, 2'd2, 32'h0000_00F0, 5'd2);
    run("R8", 3'd4, 2'd2, 32'h0010_0000, 5'd0);
    run("R8", 3'd3, 2'd2, 32'h5555_5555, 5'd0);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    chk("R1", "done idle", 32'(done_o), 32'd0);
    @(negedge clk_i);
    chk("R1", "done idle", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_test();
    t_idle();
    t_modify();
    t_modulo();
    t_scan();
    t_empty();
    t_hold();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule